// File: doc/BRIEF.md
# USB PD Transmit Framing Sequencer

This block turns one USB Power Delivery message into a serial bit stream for a biphase line encoder sitting next to it. After a start strobe it emits a fixed preamble, four programmable K-code symbols that open the packet, the payload bytes translated through the 4b5b symbol table, the 4b5b-coded CRC-32 of that payload, and a closing end-of-packet K-code. The line encoder sets the pace: it raises `bit_en_i` for one clock each time it takes the bit on `bit_o`, and the sequencer moves on to the next bit at that edge.

Payload bytes arrive through a valid/ready stream. The sequencer fetches them one byte ahead of use and holds at most one waiting byte. The byte count comes from a size input that is captured at start. A second transmit-mode code asks for a hard reset. From idle this sends a preamble followed by the hard-reset ordered set. While a normal message is running, the same request cuts the message off at the end of the symbol or preamble bit in flight, sends an end-of-packet code at once, and then sends the hard-reset sequence. No flag marks that the message was cut short.

Top module: `usbpd_tx_framer`

## Requirements
- R1: Out of reset, and whenever no transmission is running, `active_o`, `bit_o`, `in_ready_o` and `done_o` are all low.
- R2: A transmission opens with 64 preamble bits that alternate and start with 0. Exactly one bit is taken per `bit_en_i` pulse, and `bit_o` does not change in a cycle without one.
- R3: After the preamble, the four 5-bit K-codes packed in `ordset_i` (captured at start) are sent. The field at bits [5k+4:5k] goes out as the k-th symbol, k = 0 first, and every symbol is shifted out bit 0 first.
- R4: Each payload byte is sent as two 4b5b symbols, low nibble first. The symbol values for nibbles 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: After the payload come eight 4b5b symbols carrying the CRC-32 of the payload bytes: reflected polynomial 0xEDB88320, start value 0xFFFFFFFF, result inverted. The CRC goes out least significant nibble first, so an empty payload sends eight symbols for nibble 0.
- R6: A normal message ends with the end-of-packet symbol 01101. One cycle after the line encoder takes its last bit, `done_o` pulses for a single cycle and `active_o` drops.
- R7: `start_i` with `mode_i` = 01 while idle sends a preamble, then 00111 three times, then 11001, and then finishes with `done_o`. No end-of-packet symbol follows.
- R8: `start_i` with `mode_i` = 01 during a normal message lets the current preamble bit or 5-bit symbol finish, sends 01101, and then sends the R7 sequence. A single `done_o` pulse comes at the very end. A request that lands during the message's own end-of-packet symbol cuts nothing.
- R9: `start_i` with any mode other than 01 while busy is ignored, and so is a hard-reset request during a hard-reset transmission. The bit stream is unchanged in both cases.
- R10: `in_ready_o` is high only during a normal message that still needs bytes and whose one-byte holding slot is empty. It drops for at least one cycle after each accepted byte, and exactly the programmed number of bytes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start or hard-reset request strobe |
| mode_i | input | 2 | Transmit mode sampled with `start_i`; 01 = hard reset |
| pay_size_i | input | SIZE_W | Number of payload bytes, captured at start |
| ordset_i | input | 20 | Four opening K-codes, captured at start |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_ready_o | output | 1 | Sequencer accepts a byte at this edge |
| bit_en_i | input | 1 | Line encoder takes `bit_o` at this edge |
| bit_o | output | 1 | Current serial bit |
| active_o | output | 1 | A transmission is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transmission |

## Verification
The bench places hard-reset requests in the preamble, in the payload, in the CRC and inside the closing end-of-packet symbol. A design that cuts at the wrong boundary drops or repeats bits. A design that inserts an extra end-of-packet after a message that had already finished shows up as an extra symbol in the stream. A zero-length payload checks that the CRC path is entered straight from the ordered set; a design that still fetched a byte or skipped the CRC would shift the whole tail. Stray start strobes during a message and a second hard-reset request during a hard-reset transmission must leave the stream untouched. A design that restarted or re-armed on them would show a changed preamble or a doubled ordered set. A design that emitted more than one done pulse for a truncated message would fail the done count.

// File: rtl/usbpd_tx_pkg.sv
package usbpd_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_SOP  = 3'd2,
        PH_DATA = 3'd3,
        PH_CRC  = 3'd4,
        PH_EOP  = 3'd5
    } phase_e;

    localparam logic [1:0]  MODE_HRST   = 2'b01;
    localparam logic [4:0]  KC_EOP      = 5'b01101;
    localparam logic [4:0]  KC_RST_A    = 5'b00111;
    localparam logic [4:0]  KC_RST_B    = 5'b11001;
    localparam logic [19:0] HRST_SET    = {KC_RST_B, KC_RST_A, KC_RST_A, KC_RST_A};
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_RF = 32'hEDB8_8320;

endpackage

// File: rtl/usbpd_sym_enc.sv
module usbpd_sym_enc (
    input  logic [3:0] nib_i,
    output logic [4:0] sym_o
);
    always_comb begin
        case (nib_i)
            4'h0: sym_o = 5'b11110;
            4'h1: sym_o = 5'b01001;
            4'h2: sym_o = 5'b10100;
            4'h3: sym_o = 5'b10101;
            4'h4: sym_o = 5'b01010;
            4'h5: sym_o = 5'b01011;
            4'h6: sym_o = 5'b01110;
            4'h7: sym_o = 5'b01111;
            4'h8: sym_o = 5'b10010;
            4'h9: sym_o = 5'b10011;
            4'hA: sym_o = 5'b10110;
            4'hB: sym_o = 5'b10111;
            4'hC: sym_o = 5'b11010;
            4'hD: sym_o = 5'b11011;
            4'hE: sym_o = 5'b11100;
            default: sym_o = 5'b11101;
        endcase
    end
endmodule

// File: rtl/usbpd_crc32_step.sv
module usbpd_crc32_step #(
    parameter logic [31:0] POLY = 32'hEDB8_8320
) (
    input  logic [31:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);
    always_comb begin
        logic [31:0] acc;
        acc = crc_i ^ {24'h0, byte_i};
        for (int i = 0; i < 8; i++) begin
            acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/usbpd_tx_framer.sv
module usbpd_tx_framer
    import usbpd_tx_pkg::*;
#(
    parameter int SIZE_W   = 10,
    parameter int PRE_BITS = 64,
    parameter int N_K      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [SIZE_W-1:0] pay_size_i,
    input  logic [19:0]       ordset_i,
    input  logic [7:0]        in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              bit_en_i,
    output logic              bit_o,
    output logic              active_o,
    output logic              done_o
);
    localparam int PC_W  = $clog2(PRE_BITS);
    localparam int K_W   = $clog2(N_K);
    localparam int ORD_W = 5 * N_K;
    localparam int N_ENC = 3;

    typedef struct packed {
        phase_e            phase;
        logic              hr_msg;
        logic              hr_pend;
        logic [4:0]        sym;
        logic [2:0]        bit_idx;
        logic [PC_W-1:0]   pre_cnt;
        logic [K_W-1:0]    k_idx;
        logic [ORD_W-1:0]  ord;
        logic [SIZE_W-1:0] size;
        logic [SIZE_W-1:0] fetched;
        logic [SIZE_W-1:0] sent;
        logic              nib_hi;
        logic [7:0]        hold;
        logic              buf_full;
        logic [7:0]        cur;
        logic [31:0]       crc;
        logic [2:0]        crc_idx;
        logic              done;
    } st_t;

    st_t q, d;

    logic [3:0]  enc_in  [N_ENC];
    logic [4:0]  enc_out [N_ENC];
    logic [31:0] crc_upd;
    logic [31:0] crc_inv;
    logic [2:0]  crc_nsel;
    logic        ready;
    logic        take_lo;

    assign crc_inv  = ~q.crc;
    assign crc_nsel = (q.phase == PH_CRC) ? (q.crc_idx + 3'd1) : 3'd0;
    assign enc_in[0] = q.hold[3:0];
    assign enc_in[1] = q.cur[7:4];
    assign enc_in[2] = crc_inv[4*int'(crc_nsel) +: 4];

    for (genvar g = 0; g < N_ENC; g++) begin : g_enc
        usbpd_sym_enc u_enc (.nib_i(enc_in[g]), .sym_o(enc_out[g]));
    end

    usbpd_crc32_step #(.POLY(CRC_POLY_RF)) u_crc (
        .crc_i (q.crc),
        .byte_i(q.hold),
        .crc_o (crc_upd)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        take_lo = 1'b0;
        ready   = (q.phase inside {PH_PRE, PH_SOP, PH_DATA}) && !q.hr_msg && !q.hr_pend
                  && !q.buf_full && (q.fetched != q.size);

        if (q.phase == PH_IDLE) begin
            if (start_i) begin
                d.phase    = PH_PRE;
                d.pre_cnt  = '0;
                d.bit_idx  = '0;
                d.hr_pend  = 1'b0;
                d.buf_full = 1'b0;
                d.fetched  = '0;
                d.sent     = '0;
                d.nib_hi   = 1'b0;
                d.crc      = CRC_SEED;
                if (mode_i == MODE_HRST) begin
                    d.hr_msg = 1'b1;
                    d.ord    = HRST_SET;
                end else begin
                    d.hr_msg = 1'b0;
                    d.ord    = ordset_i;
                    d.size   = pay_size_i;
                end
            end
        end else begin
            if (bit_en_i) begin
                if (q.phase != PH_PRE && q.bit_idx != 3'd4) begin
                    d.bit_idx = q.bit_idx + 3'd1;
                end else begin
                    d.bit_idx = '0;
                    if (q.hr_pend && !q.hr_msg && q.phase != PH_EOP) begin
                        d.phase = PH_EOP;
                        d.sym   = KC_EOP;
                    end else begin
                        case (q.phase)
                            PH_PRE: begin
                                if (q.pre_cnt == PC_W'(PRE_BITS - 1)) begin
                                    d.phase = PH_SOP;
                                    d.k_idx = '0;
                                    d.sym   = q.ord[4:0];
                                end else begin
                                    d.pre_cnt = q.pre_cnt + 1'b1;
                                end
                            end
                            PH_SOP: begin
                                if (q.k_idx == K_W'(N_K - 1)) begin
                                    if (q.hr_msg) begin
                                        d.phase = PH_IDLE;
                                        d.done  = 1'b1;
                                    end else if (q.size == '0) begin
                                        d.phase   = PH_CRC;
                                        d.crc_idx = '0;
                                        d.sym     = enc_out[2];
                                    end else begin
                                        take_lo = 1'b1;
                                    end
                                end else begin
                                    d.k_idx = q.k_idx + 1'b1;
                                    d.sym   = q.ord[5*(int'(q.k_idx) + 1) +: 5];
                                end
                            end
                            PH_DATA: begin
                                if (!q.nib_hi) begin
                                    d.sym    = enc_out[1];
                                    d.nib_hi = 1'b1;
                                end else begin
                                    d.sent = q.sent + 1'b1;
                                    if ((q.sent + 1'b1) == q.size) begin
                                        d.phase   = PH_CRC;
                                        d.crc_idx = '0;
                                        d.sym     = enc_out[2];
                                    end else begin
                                        take_lo = 1'b1;
                                    end
                                end
                            end
                            PH_CRC: begin
                                if (q.crc_idx == 3'd7) begin
                                    d.phase = PH_EOP;
                                    d.sym   = KC_EOP;
                                end else begin
                                    d.crc_idx = q.crc_idx + 3'd1;
                                    d.sym     = enc_out[2];
                                end
                            end
                            PH_EOP: begin
                                if (q.hr_pend) begin
                                    d.phase   = PH_PRE;
                                    d.hr_msg  = 1'b1;
                                    d.hr_pend = 1'b0;
                                    d.ord     = HRST_SET;
                                    d.pre_cnt = '0;
                                end else begin
                                    d.phase = PH_IDLE;
                                    d.done  = 1'b1;
                                end
                            end
                            default: d.phase = PH_IDLE;
                        endcase
                    end
                end
            end
            if (start_i && mode_i == MODE_HRST && !q.hr_msg && !d.hr_msg) begin
                d.hr_pend = 1'b1;
            end
        end

        if (take_lo) begin
            d.phase    = PH_DATA;
            d.sym      = enc_out[0];
            d.cur      = q.hold;
            d.crc      = crc_upd;
            d.buf_full = 1'b0;
            d.nib_hi   = 1'b0;
        end

        if (ready && in_valid_i) begin
            d.hold     = in_data_i;
            d.buf_full = 1'b1;
            d.fetched  = q.fetched + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready_o = ready;
    assign active_o   = (q.phase != PH_IDLE);
    assign done_o     = q.done;
    assign bit_o      = (q.phase == PH_PRE)  ? q.pre_cnt[0] :
                        (q.phase == PH_IDLE) ? 1'b0 : q.sym[q.bit_idx];

endmodule

// File: rtl/usbpd_tx_framer_chk.sv
module usbpd_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid_i,
    input logic in_ready_o,
    input logic bit_en_i,
    input logic bit_o,
    input logic active_o,
    input logic done_o
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (!bit_o && !in_ready_o));

    a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> $stable(bit_o));

    a_r6_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> done_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !active_o);

    a_r10_one_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o);
endmodule

bind usbpd_tx_framer usbpd_tx_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .bit_en_i  (bit_en_i),
    .bit_o     (bit_o),
    .active_o  (active_o),
    .done_o    (done_o)
);

// File: tb/usbpd_tx_framer_tb.sv
module usbpd_tx_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [9:0]  pay_size_i = '0;
    logic [19:0] ordset_i = '0;
    logic [7:0]  in_data_i = '0;
    logic        in_valid_i = 1'b0;
    logic        in_ready_o;
    logic        bit_en_i = 1'b0;
    logic        bit_o;
    logic        active_o;
    logic        done_o;

    always #10 clk = ~clk;

    usbpd_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .pay_size_i(pay_size_i), .ordset_i(ordset_i), .in_data_i(in_data_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .bit_en_i(bit_en_i),
        .bit_o(bit_o), .active_o(active_o), .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;
    bit          exp_q[$];
    string       tag_q[$];
    logic [7:0]  src_q[$];
    int src_idx = 0;
    int bits_seen = 0;
    int done_cnt = 0;
    int acc_cnt = 0;
    string last_tag = "R6";

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                               5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic logic [31:0] crc_of_src();
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (src_q[i]) begin
            c ^= {24'h0, src_q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_sym(input logic [4:0] s, input string t);
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(s[i]);
            tag_q.push_back(t);
        end
    endtask

    task automatic push_pre(input string t);
        for (int i = 0; i < 64; i++) begin
            exp_q.push_back(i[0]);
            tag_q.push_back(t);
        end
    endtask

    task automatic push_hrst(input string t);
        push_pre(t);
        push_sym(5'b00111, t);
        push_sym(5'b00111, t);
        push_sym(5'b00111, t);
        push_sym(5'b11001, t);
    endtask

    // Line encoder model and scoreboard monitor: one bit every 4 cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 4;
            bit_en_i = (ph == 0);
            if (done_o) done_cnt++;
            if (bit_en_i && active_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, last_tag, "extra bit after expected end", int'(bit_o), -1);
                end else begin
                    automatic bit    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    last_tag = t;
                    check(bit_o == e, t, $sformatf("bit %0d", bits_seen), int'(bit_o), int'(e));
                end
                bits_seen++;
            end
        end
    end

    // Payload source.
    initial begin
        forever begin
            @(negedge clk);
            if (in_valid_i && in_ready_o) begin
                @(posedge clk);
                #1;
                acc_cnt++;
                src_idx++;
                if (src_idx < src_q.size()) in_data_i = src_q[src_idx];
                else in_valid_i = 1'b0;
            end
        end
    end

    task automatic pulse_start(input logic [1:0] m, input logic [9:0] sz, input logic [19:0] os);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; pay_size_i = sz; ordset_i = os;
        @(negedge clk);
        start_i = 1'b0; mode_i = 2'b00;
    endtask

    task automatic finish_check(input int d0, input string req);
        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        check(done_cnt == d0 + 1, req, "done pulse count", done_cnt - d0, 1);
        check(active_o == 1'b0, req, "active after end", int'(active_o), 0);
    endtask

    // hr_at / ign_at: bit count after which a hard-reset / ignored normal start is issued.
    task automatic run_msg(input int size, input logic [19:0] os, input int seed,
                           input int hr_at, input int ign_at);
        int d0;
        int full;
        logic [31:0] crc;
        src_q.delete();
        for (int i = 0; i < size; i++) src_q.push_back(8'((seed + i * 61) ^ (i << 3)));
        push_pre("R2");
        for (int k = 0; k < 4; k++) push_sym(os[5*k +: 5], "R3");
        foreach (src_q[i]) begin
            push_sym(enc(src_q[i][3:0]), "R4");
            push_sym(enc(src_q[i][7:4]), "R4");
        end
        crc = crc_of_src();
        for (int n = 0; n < 8; n++) push_sym(enc(crc[4*n +: 4]), "R5");
        push_sym(5'b01101, "R6");
        full = exp_q.size();
        if (hr_at >= 0) begin
            automatic int cut = (hr_at < 64) ? hr_at + 1 : 64 + 5 * ((hr_at - 64) / 5 + 1);
            if (cut < full) begin
                while (exp_q.size() > cut) begin
                    void'(exp_q.pop_back());
                    void'(tag_q.pop_back());
                end
                push_sym(5'b01101, "R8");
            end
            push_hrst("R8");
        end
        acc_cnt = 0;
        src_idx = 0;
        bits_seen = 0;
        d0 = done_cnt;
        if (size > 0) begin
            in_data_i = src_q[0];
            in_valid_i = 1'b1;
        end
        pulse_start(2'b00, 10'(size), os);
        if (hr_at >= 0) begin
            wait (bits_seen == hr_at);
            pulse_start(2'b01, 10'd0, 20'h0);
        end
        if (ign_at >= 0) begin
            wait (bits_seen == ign_at);
            pulse_start(2'b10, 10'd7, 20'hABCDE);
            wait (bits_seen == ign_at + 3);
            pulse_start(2'b00, 10'd3, 20'h12345);
        end
        finish_check(d0, (hr_at >= 0) ? "R8" : "R6");
        if (hr_at < 0) check(acc_cnt == size, "R10", "bytes accepted", acc_cnt, size);
        in_valid_i = 1'b0;
        @(negedge clk);
        check(in_ready_o == 1'b0, "R10", "ready after end", int'(in_ready_o), 0);
    endtask

    task automatic run_hrst(input int ign_at);
        int d0;
        push_hrst("R7");
        bits_seen = 0;
        d0 = done_cnt;
        pulse_start(2'b01, 10'd0, 20'h0);
        if (ign_at >= 0) begin
            wait (bits_seen == ign_at);
            pulse_start(2'b01, 10'd0, 20'h0);   // R9: ignored during hard reset
        end
        finish_check(d0, "R7");
        check(in_ready_o == 1'b0, "R10", "ready during/after hard reset", int'(in_ready_o), 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        check(active_o == 1'b0, "R1", "active in reset", int'(active_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(active_o == 1'b0, "R1", "active after reset", int'(active_o), 0);
        check(bit_o == 1'b0, "R1", "bit after reset", int'(bit_o), 0);
        check(in_ready_o == 1'b0, "R1", "ready after reset", int'(in_ready_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);

        run_msg(2, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h5A, -1, -1);   // R2..R6
        run_msg(0, {5'b00110, 5'b11000, 5'b00110, 5'b11000}, 0, -1, -1);       // R5 empty
        run_msg(5, {5'b11001, 5'b00111, 5'b10001, 5'b11000}, 8'hC3, -1, -1);   // R4 R10
        run_hrst(-1);                                                          // R7
        run_msg(3, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h17, 10, -1);   // R8 preamble
        run_msg(4, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h29, 87, -1);   // R8 payload
        run_msg(2, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h3E, 110, -1);  // R8 CRC
        run_msg(2, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h44, 146, -1);  // R8 inside EOP
        run_msg(3, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'h81, -1, 30);   // R9 ignored start
        run_hrst(40);                                                          // R9 hard reset repeat
        run_msg(1, {5'b10001, 5'b11000, 5'b11000, 5'b11000}, 8'hF0, -1, -1);   // recovery
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule